// File: doc/BRIEF.md
# USB Host Port Attach and Bus Reset Controller

This block sits behind the transceiver of one downstream USB host port. It watches the sampled D+ and D- levels and decides when a device has attached or detached. On attach it works out whether the device signals at full speed or at low speed. On request from software it drives a bus reset by forcing SE0 onto the port for a fixed interval. All intervals are counted in ticks of a 48 MHz clock-enable, so the block runs from any faster system clock.

Software reaches the block through a control word and an event flag word. The control word holds a host-mode enable, a bus reset request, and an interrupt enable for each event. The flag word holds three sticky events: attach, detach and reset done. Software clears a flag by writing 0 to it. The interrupt output is high while any enabled flag is set. The connect status and the speed flag are read directly as outputs.

Top module: `usbpa_port_ctrl`

## Requirements
- R1: After reset, `conn_o`, `flags_o`, `irq_o`, `oe_o` and `se0_o` are all 0, and `ctl_o[1]` is 0.
- R2: `conn_o` rises only after the line has held one idle state without a break for ATTACH_TICKS ticks. The idle states are full speed {dm,dp}=01 and low speed {dm,dp}=10. A change of line state before then restarts the count, and a shorter hold leaves `conn_o` at 0.
- R3: On attach, `fullspeed_o` becomes 1 for line state {dm,dp}=01 and 0 for {dm,dp}=10. It stays unchanged while `conn_o` remains 1.
- R4: Each attach sets the attach event flag, `flags_o[0]`.
- R5: `irq_o` is 1 exactly while some flag in `flags_o[k]` is set with its enable in `ctl_o[k+2]` also set. Writing `flg_wdata_i[k]`=0 with `flg_wr_i` clears flag k. Writing 1 leaves that flag unchanged. A flag being set in the same cycle wins over a clear.
- R6: While attached, SE0 ({dm,dp}=00) held for DETACH_TICKS ticks drops `conn_o` and sets the detach flag, `flags_o[1]`. A shorter SE0 leaves `conn_o` at 1 and raises no flag.
- R7: Attach and detach detection, `conn_o`, `fullspeed_o`, `flags_o[0]` and `flags_o[1]` work the same whether host mode (`ctl_o[0]`) is 0 or 1.
- R8: A control write with bit 1 set starts a bus reset only when the same write also sets host enable (bit 0). Otherwise `se0_o` stays 0.
- R9: During a bus reset, `oe_o` and `se0_o` are both 1 for RESET_TICKS ticks. `conn_o` is held at 0 and the detach flag is not set.
- R10: When the reset ends, `se0_o` and `oe_o` fall, `ctl_o[1]` (the request bit) reads 0, and the reset done flag, `flags_o[2]`, is set.
- R11: After a bus reset, a device that is still present qualifies again under R2 and sets `flags_o[0]` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 48 MHz clock-enable pulse |
| dp_i | input | 1 | Sampled D+ level |
| dm_i | input | 1 | Sampled D- level |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 5 | Control data: bit0 host enable, bit1 bus reset request, bit2 attach irq enable, bit3 detach irq enable, bit4 reset done irq enable |
| flg_wr_i | input | 1 | Flag word write strobe |
| flg_wdata_i | input | 3 | Write 0 to clear: bit0 attach, bit1 detach, bit2 reset done |
| ctl_o | output | 5 | Control readback; bit1 is 1 while a bus reset runs |
| flags_o | output | 3 | Event flags: bit0 attach, bit1 detach, bit2 reset done |
| conn_o | output | 1 | Device attached status |
| fullspeed_o | output | 1 | 1 for a full-speed device, 0 for low speed |
| irq_o | output | 1 | Interrupt request |
| oe_o | output | 1 | Port drive enable |
| se0_o | output | 1 | Drive SE0 on the port |

## Verification
The bench uses ATTACH_TICKS=8, DETACH_TICKS=6 and RESET_TICKS=20, with one tick on every second clock and a two-stage line synchronizer. At these values the bench can reach the cases below in a few dozen cycles each, where the default 10 ms reset would take hundreds of thousands of ticks:
- line holds that are a few ticks short of qualification,
- restarts caused by a change of speed state,
- SE0 glitches shorter than the detach window,
- a complete bus reset whose measured length is compared with 2*RESET_TICKS cycles,
- re-qualification of the device after the reset.

// File: rtl/usbpa_pkg.sv
package usbpa_pkg;

   // line state packed as {dm, dp}
   typedef enum logic [1:0] {
      LN_SE0 = 2'b00,
      LN_FS  = 2'b01,
      LN_LS  = 2'b10,
      LN_SE1 = 2'b11
   } line_e;

   localparam int unsigned NUM_FLAGS = 3;
   localparam int unsigned FLG_ATT   = 0;
   localparam int unsigned FLG_DET   = 1;
   localparam int unsigned FLG_RST   = 2;

   localparam int unsigned CTL_W     = 5;
   localparam int unsigned CTL_HOST  = 0;
   localparam int unsigned CTL_BRST  = 1;
   localparam int unsigned CTL_IE0   = 2;

endpackage

// File: rtl/usbpa_line_sync.sv
module usbpa_line_sync
   import usbpa_pkg::*;
#(
   parameter int unsigned STAGES = 2
) (
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  dp_i,
   input  logic  dm_i,
   output line_e line_o
);

   generate
      if (STAGES == 0) begin : g_direct
         assign line_o = line_e'({dm_i, dp_i});
      end else begin : g_chain
         logic [1:0] pipe_q [STAGES];
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               for (int i = 0; i < STAGES; i++) pipe_q[i] <= 2'b00;
            end else begin
               pipe_q[0] <= {dm_i, dp_i};
               for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            end
         end
         assign line_o = line_e'(pipe_q[STAGES-1]);
      end
   endgenerate

endmodule

// File: rtl/usbpa_attach_fsm.sv
module usbpa_attach_fsm
   import usbpa_pkg::*;
#(
   parameter int unsigned ATTACH_TICKS = 120,
   parameter int unsigned DETACH_TICKS = 120
) (
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  tick_i,
   input  line_e line_i,
   input  logic  hold_i,
   output logic  conn_o,
   output logic  fs_o,
   output logic  att_ev_o,
   output logic  det_ev_o
);

   localparam int unsigned MAXT = (ATTACH_TICKS > DETACH_TICKS) ? ATTACH_TICKS : DETACH_TICKS;
   localparam int unsigned CW   = $clog2(MAXT + 1);
   localparam logic [CW-1:0] ATT_LAST = CW'(ATTACH_TICKS - 1);
   localparam logic [CW-1:0] DET_LAST = CW'(DETACH_TICKS - 1);

   line_e         cand_q;
   logic [CW-1:0] cnt_q;
   logic          conn_q, fs_q;
   logic          idle_line, same_line, att_done, det_done;

   assign idle_line = (line_i == LN_FS) || (line_i == LN_LS);
   assign same_line = (line_i == cand_q);
   assign att_done  = !hold_i && !conn_q && same_line && idle_line && tick_i && (cnt_q == ATT_LAST);
   assign det_done  = !hold_i && conn_q && (line_i == LN_SE0) && tick_i && (cnt_q == DET_LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cand_q <= LN_SE0;
         cnt_q  <= '0;
         conn_q <= 1'b0;
         fs_q   <= 1'b0;
      end else if (hold_i) begin
         cand_q <= LN_SE0;
         cnt_q  <= '0;
         conn_q <= 1'b0;
      end else if (!conn_q) begin
         if (!same_line) begin
            cand_q <= line_i;
            cnt_q  <= '0;
         end else if (att_done) begin
            conn_q <= 1'b1;
            fs_q   <= (line_i == LN_FS);
            cnt_q  <= '0;
         end else if (tick_i && idle_line) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else begin
         if (line_i != LN_SE0) begin
            cnt_q <= '0;
         end else if (det_done) begin
            conn_q <= 1'b0;
            cand_q <= LN_SE0;
            cnt_q  <= '0;
         end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign conn_o   = conn_q;
   assign fs_o     = fs_q;
   assign att_ev_o = att_done;
   assign det_ev_o = det_done;

endmodule

// File: rtl/usbpa_bus_reset.sv
module usbpa_bus_reset #(
   parameter int unsigned RESET_TICKS = 480000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic start_i,
   output logic active_o,
   output logic done_o
);

   localparam int unsigned RW = (RESET_TICKS > 1) ? $clog2(RESET_TICKS) : 1;
   localparam logic [RW-1:0] LAST = RW'(RESET_TICKS - 1);

   logic [RW-1:0] cnt_q;
   logic          act_q;
   logic          fin;

   assign fin = act_q && tick_i && (cnt_q == LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (!act_q) begin
         if (start_i) begin
            act_q <= 1'b1;
            cnt_q <= '0;
         end
      end else if (fin) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (tick_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign active_o = act_q;
   assign done_o   = fin;

endmodule

// File: rtl/usbpa_evt_flags.sv
module usbpa_evt_flags #(
   parameter int unsigned N = 3
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] set_i,
   input  logic         wr_i,
   input  logic [N-1:0] wdata_i,
   input  logic [N-1:0] en_i,
   output logic [N-1:0] flags_o,
   output logic         irq_o
);

   logic [N-1:0] flg_q;

   for (genvar k = 0; k < N; k++) begin : g_flag
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                  flg_q[k] <= 1'b0;
         else if (set_i[k])            flg_q[k] <= 1'b1;
         else if (wr_i && !wdata_i[k]) flg_q[k] <= 1'b0;
      end
   end

   assign flags_o = flg_q;
   assign irq_o   = |(flg_q & en_i);

endmodule

// File: rtl/usbpa_port_ctrl.sv
module usbpa_port_ctrl
   import usbpa_pkg::*;
#(
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned ATTACH_TICKS = 120,
   parameter int unsigned DETACH_TICKS = 120,
   parameter int unsigned RESET_TICKS  = 480000
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 tick_i,
   input  logic                 dp_i,
   input  logic                 dm_i,
   input  logic                 ctl_wr_i,
   input  logic [CTL_W-1:0]     ctl_wdata_i,
   input  logic                 flg_wr_i,
   input  logic [NUM_FLAGS-1:0] flg_wdata_i,
   output logic [CTL_W-1:0]     ctl_o,
   output logic [NUM_FLAGS-1:0] flags_o,
   output logic                 conn_o,
   output logic                 fullspeed_o,
   output logic                 irq_o,
   output logic                 oe_o,
   output logic                 se0_o
);

   if (ATTACH_TICKS < 1) begin : g_bad_att
      $error("ATTACH_TICKS must be at least 1");
   end
   if (DETACH_TICKS < 1) begin : g_bad_det
      $error("DETACH_TICKS must be at least 1");
   end
   if (RESET_TICKS < 1) begin : g_bad_rst
      $error("RESET_TICKS must be at least 1");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES above 4 is not supported");
   end

   line_e                line;
   logic                 host_en_q;
   logic [NUM_FLAGS-1:0] ie_q;
   logic                 rst_start, rst_active, rst_done;
   logic                 att_ev, det_ev;
   logic [NUM_FLAGS-1:0] set_vec;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         host_en_q <= 1'b0;
         ie_q      <= '0;
      end else if (ctl_wr_i) begin
         host_en_q <= ctl_wdata_i[CTL_HOST];
         ie_q      <= ctl_wdata_i[CTL_IE0 +: NUM_FLAGS];
      end
   end

   assign rst_start = ctl_wr_i && ctl_wdata_i[CTL_BRST] && ctl_wdata_i[CTL_HOST];

   usbpa_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .dp_i   (dp_i),
      .dm_i   (dm_i),
      .line_o (line)
   );

   usbpa_attach_fsm #(.ATTACH_TICKS(ATTACH_TICKS), .DETACH_TICKS(DETACH_TICKS)) u_att (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .line_i   (line),
      .hold_i   (rst_active),
      .conn_o   (conn_o),
      .fs_o     (fullspeed_o),
      .att_ev_o (att_ev),
      .det_ev_o (det_ev)
   );

   usbpa_bus_reset #(.RESET_TICKS(RESET_TICKS)) u_brst (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .start_i  (rst_start),
      .active_o (rst_active),
      .done_o   (rst_done)
   );

   always_comb begin
      set_vec          = '0;
      set_vec[FLG_ATT] = att_ev;
      set_vec[FLG_DET] = det_ev;
      set_vec[FLG_RST] = rst_done;
   end

   usbpa_evt_flags #(.N(NUM_FLAGS)) u_flg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (set_vec),
      .wr_i    (flg_wr_i),
      .wdata_i (flg_wdata_i),
      .en_i    (ie_q),
      .flags_o (flags_o),
      .irq_o   (irq_o)
   );

   assign ctl_o = {ie_q, rst_active, host_en_q};
   assign oe_o  = rst_active;
   assign se0_o = rst_active;

endmodule

// File: rtl/usbpa_port_chk.sv
module usbpa_port_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [4:0] ctl_o,
   input logic [2:0] flags_o,
   input logic       conn_o,
   input logic       fullspeed_o,
   input logic       irq_o,
   input logic       se0_o
);

   // R9
   reset_drops_conn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      se0_o && $past(se0_o) |-> !conn_o);

   // R9
   no_detach_in_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      se0_o |=> !$rose(flags_o[1]));

   // R10
   reset_end_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(se0_o) |-> (flags_o[2] && !ctl_o[1]));

   // R8
   reset_needs_host_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(se0_o) |-> ctl_o[0]);

   // R4
   attach_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(conn_o) |-> flags_o[0]);

   // R3
   speed_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      conn_o && $past(conn_o) |-> $stable(fullspeed_o));

   // R5
   irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_o == 3'b000) |-> !irq_o);

endmodule

bind usbpa_port_ctrl usbpa_port_chk u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .ctl_o       (ctl_o),
   .flags_o     (flags_o),
   .conn_o      (conn_o),
   .fullspeed_o (fullspeed_o),
   .irq_o       (irq_o),
   .se0_o       (se0_o)
);

// File: tb/usbpa_port_ctrl_tb.sv
`timescale 1ns/1ps
module usbpa_port_ctrl_tb;

   localparam int unsigned ATT = 8;
   localparam int unsigned DET = 6;
   localparam int unsigned RST = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       dev_dp = 1'b0, dev_dm = 1'b0;
   logic       dp, dm;
   logic       ctl_wr = 1'b0;
   logic [4:0] ctl_wd = '0;
   logic       flg_wr = 1'b0;
   logic [2:0] flg_wd = '0;
   logic [4:0] ctl;
   logic [2:0] flags;
   logic       conn, fs, irq, oe, se0;

   int n_chk = 0;
   int n_fail = 0;
   int exp_q[$];
   logic [2:0] prev_flags = '0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   assign dp = se0 ? 1'b0 : dev_dp;
   assign dm = se0 ? 1'b0 : dev_dm;

   usbpa_port_ctrl #(.SYNC_STAGES(2), .ATTACH_TICKS(ATT), .DETACH_TICKS(DET), .RESET_TICKS(RST)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .dp_i(dp), .dm_i(dm),
      .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wd), .flg_wr_i(flg_wr), .flg_wdata_i(flg_wd),
      .ctl_o(ctl), .flags_o(flags), .conn_o(conn), .fullspeed_o(fs), .irq_o(irq),
      .oe_o(oe), .se0_o(se0)
   );

   initial begin
      forever begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic line(input logic p, input logic m);
      dev_dp = p; dev_dm = m;
   endtask

   task automatic expect_evt(input int bitno);
      exp_q.push_back(bitno);
   endtask

   task automatic wr_ctl(input logic [4:0] d);
      ctl_wd = d; ctl_wr = 1'b1;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic wr_flg(input logic [2:0] d);
      flg_wd = d; flg_wr = 1'b1;
      @(negedge clk);
      flg_wr = 1'b0;
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   // monitor: every rising flag must match the next expected event
   always @(negedge clk) begin
      if (rst_n) begin
         for (int k = 0; k < 3; k++) begin
            if (flags[k] && !prev_flags[k]) begin
               if (exp_q.size() == 0) check("R4 R6 R10 unexpected event", k, -1);
               else check("R4 R6 R10 event order", k, exp_q.pop_front());
            end
         end
      end
      prev_flags = flags;
   end

   initial begin
      repeat (30000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      int len;
      cyc(4);
      // R1 reset state
      check("R1 conn", conn, 0);
      check("R1 flags", flags, 0);
      check("R1 se0/oe/irq", {se0, oe, irq, ctl[1]}, 0);
      rst_n = 1'b1;
      cyc(4);

      // R2 short holds and a speed change restart do not qualify
      line(1, 0); cyc(2*(ATT-2));
      line(0, 1); cyc(2*(ATT-2));
      line(0, 0); cyc(20);
      check("R2 short hold conn", conn, 0);
      check("R2 short hold flags", flags, 0);

      // R2 R3 R4 full-speed attach, no irq enabled
      expect_evt(0);
      line(1, 0); cyc(2*ATT + 12);
      check("R2 fs attach conn", conn, 1);
      check("R3 fs speed", fs, 1);
      check("R4 attach flag", flags[0], 1);
      check("R5 irq masked", irq, 0);

      // R5 enable gates irq, write 1 keeps, write 0 clears
      wr_ctl(5'b00100);
      check("R5 irq enabled", irq, 1);
      wr_flg(3'b111);
      check("R5 write one keeps", flags[0], 1);
      wr_flg(3'b110);
      check("R5 clear flag", flags[0], 0);
      check("R5 irq clears", irq, 0);

      // R6 short SE0 ignored
      line(0, 0); cyc(2*(DET-3));
      line(1, 0); cyc(20);
      check("R6 short se0 conn", conn, 1);
      check("R6 short se0 flags", flags, 0);

      // R6 real detach
      expect_evt(1);
      line(0, 0); cyc(2*DET + 12);
      check("R6 detach conn", conn, 0);
      check("R6 detach flag", flags[1], 1);
      wr_flg(3'b000);

      // R7 low-speed attach with host mode off
      check("R7 host off", ctl[0], 0);
      expect_evt(0);
      line(0, 1); cyc(2*ATT + 12);
      check("R7 ls attach conn", conn, 1);
      check("R3 ls speed", fs, 0);
      wr_flg(3'b000);

      // R8 reset request without host enable
      wr_ctl(5'b00010);
      cyc(4);
      check("R8 no reset se0", se0, 0);
      check("R8 request bit", ctl[1], 0);

      // R9 R10 R11 bus reset then re-qualification
      expect_evt(2);
      expect_evt(0);
      wr_ctl(5'b10011);
      check("R9 se0 on", {se0, oe}, 3);
      cyc(2);
      check("R9 conn dropped", conn, 0);
      len = 3;
      while (se0 && len < 4*RST + 20) begin
         cyc(1); len++;
      end
      check("R9 duration low", int'(len >= 2*RST - 2), 1);
      check("R9 duration high", int'(len <= 2*RST + 2), 1);
      check("R10 se0 off", {se0, oe}, 0);
      check("R10 request bit cleared", ctl[1], 0);
      check("R10 reset done flag", flags[2], 1);
      check("R9 no detach flag", flags[1], 0);
      check("R10 irq", irq, 1);
      cyc(2*ATT + 12);
      check("R11 requalified conn", conn, 1);
      check("R11 attach flag again", flags[0], 1);
      cyc(4);
      check("R11 queue drained", exp_q.size(), 0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule